// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static memory of 32-bit words with 19 address bits. The memory has one active-low select per byte lane, one shared write strobe and one shared output-enable strobe. The host asks for one word access at a time: a request with a write flag, an address, write data and a 4-bit lane mask. The controller turns that into a timed strobe sequence on the memory pins and answers with a one-cycle done pulse, plus read data for reads.

Every timing figure is a parameter counted in clock cycles, rounded up from the nanosecond limits of the chosen memory speed grade. A write presents address and data first, then pulls the selected lane selects and the write strobe low together for the pulse width, then raises them while still holding address and data. A read releases the data bus, selects the lanes with the output enable still high for a turnaround period, then lowers the output enable for the access time and samples the bus on the last edge of that count. All pin outputs come straight from flip-flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst` is high, every lane select, the write strobe and the output enable are high, `done` is low, `rdata` is zero and the data bus is not driven.
- R2: A write accepted on a clock edge shows its address and data on the pins with all strobes high for T_SA cycles. After that, the selected lane selects and the write strobe are low together for exactly T_PWE cycles.
- R3: After the write strobe rises, the address and write data stay on the pins with all strobes high for T_HD more cycles. `done` then goes high for one cycle.
- R4: Mask bit i selects byte lane i, which is data bits 8i+7..8i and select pin i. Lanes whose mask bit is clear keep their select high, so their stored bytes do not change.
- R5: The output enable stays high during every write, and the write strobe stays high during every read.
- R6: A read keeps the data bus released for its whole duration. It holds the selected lane selects low with the output enable high for T_TURN cycles, then lowers the output enable for T_AA cycles while the address is held.
- R7: Read data is sampled on the edge that ends the T_AA count, and `done` is high for exactly the next cycle. Lanes with a clear mask bit read as zero.
- R8: A request is taken only while the controller is idle. While an access is running, changes to `req`, `addr`, `wdata` and `mask` have no effect on the pins or the result.
- R9: Between accesses, all lane selects, the write strobe and the output enable are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held by the host until `done` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address |
| wdata | input | 32 | Write data |
| mask | input | 4 | Lane mask, bit i selects byte lane i |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, zero in unselected lanes |
| sram_addr | output | 19 | Memory address pins |
| sram_cs_n | output | 4 | Active-low lane selects |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq | inout | 32 | Bidirectional memory data bus |

## Verification
The strobes move on the same edge that accepts a request. A write's `done` is due T_SA+T_PWE+T_HD edges after the accepting edge, and a read's `done` T_TURN+T_AA edges after it, with `rdata` valid from that same cycle. The bench pushes one expected pin vector per cycle into a queue as soon as it sees the accepting edge. It pops and compares one vector at every falling edge, so each strobe, address, bus value and `done` is checked in exactly the cycle it is due. A behavioural memory in the bench answers on the pins, so read results depend on what the write strobes actually stored.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSU,   // write: address/data setup
    ST_WPL,   // write: select and strobe low
    ST_WHD,   // write: hold after strobe
    ST_RSU,   // read: bus turnaround, lanes selected
    ST_RAC    // read: output enable low, access count
  } lane_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int T_SA   = 1,
  parameter int T_PWE  = 2,
  parameter int T_HD   = 1,
  parameter int T_TURN = 1,
  parameter int T_AA   = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  logic     wr,
  output lane_st_e st,
  output lane_st_e st_nxt,
  output logic     accept,
  output logic     fin,
  output logic     cap
);

  localparam int TMAX = imax(imax(imax(T_SA, T_PWE), imax(T_HD, T_TURN)), T_AA);
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt_q;
    if (st == ST_IDLE) begin
      if (req) begin
        st_nxt  = wr ? ST_WSU : ST_RSU;
        cnt_nxt = wr ? CW'(T_SA - 1) : CW'(T_TURN - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end else begin
      unique case (st)
        ST_WSU:  begin st_nxt = ST_WPL;  cnt_nxt = CW'(T_PWE - 1); end
        ST_WPL:  begin st_nxt = ST_WHD;  cnt_nxt = CW'(T_HD - 1);  end
        ST_RSU:  begin st_nxt = ST_RAC;  cnt_nxt = CW'(T_AA - 1);  end
        default: begin st_nxt = ST_IDLE; cnt_nxt = '0;             end
      endcase
    end
  end

  assign accept = (st == ST_IDLE) && req;
  assign fin    = (st != ST_IDLE) && (st_nxt == ST_IDLE);
  assign cap    = (st == ST_RAC) && (st_nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st    <= st_nxt;
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/sram_lane_pins.sv
`timescale 1ns/1ps
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int AW    = 19,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_st_e         st,
  input  lane_st_e         st_nxt,
  input  logic             accept,
  input  logic             fin,
  input  logic             cap,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             drv,
  output logic [AW-1:0]    pin_addr,
  output logic [LANES-1:0] pin_cs_n,
  output logic             pin_we_n,
  output logic             pin_oe_n,
  output logic             done,
  output logic [DW-1:0]    rdata
);

  localparam int LW = DW / LANES;

  logic [LANES-1:0] mask_q, lane_sel;
  logic [DW-1:0]    bit_mask;
  logic             sel_nxt, wr_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_mask[g*LW +: LW] = {LW{mask_q[g]}};
  end

  assign lane_sel = accept ? mask : mask_q;
  assign sel_nxt  = (st_nxt == ST_WPL) || (st_nxt == ST_RSU) || (st_nxt == ST_RAC);
  assign wr_nxt   = (st_nxt == ST_WSU) || (st_nxt == ST_WPL) || (st_nxt == ST_WHD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      pin_addr <= '0;
      dq_out   <= '0;
      drv      <= 1'b0;
      pin_cs_n <= '1;
      pin_we_n <= 1'b1;
      pin_oe_n <= 1'b1;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mask_q   <= mask;
        pin_addr <= addr;
        dq_out   <= wdata;
      end
      pin_cs_n <= sel_nxt ? ~lane_sel : '1;
      pin_we_n <= (st_nxt != ST_WPL);
      pin_oe_n <= (st_nxt != ST_RAC);
      drv      <= wr_nxt;
      done     <= fin;
      if (cap) rdata <= dq_in & bit_mask;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!pin_we_n && !pin_oe_n)); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_oe_n) |-> (!drv && $past(!drv))); // R6
  AST_WE_LANES: assert property (@(posedge clk) disable iff (rst)
    !pin_we_n |-> (pin_cs_n == ~mask_q)); // R4
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (&pin_cs_n && pin_we_n && pin_oe_n && !drv)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(pin_addr)); // R8

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 32,
  parameter int LANES  = 4,
  parameter int T_SA   = 1,
  parameter int T_PWE  = 2,
  parameter int T_HD   = 1,
  parameter int T_TURN = 1,
  parameter int T_AA   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] mask,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [AW-1:0]    sram_addr,
  output logic [LANES-1:0] sram_cs_n,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  inout  wire  [DW-1:0]    sram_dq
);

  lane_st_e      st, st_nxt;
  logic          accept, fin, cap, drv;
  logic [DW-1:0] dq_out;

  sram_lane_seq #(
    .T_SA(T_SA), .T_PWE(T_PWE), .T_HD(T_HD), .T_TURN(T_TURN), .T_AA(T_AA)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr),
    .st(st), .st_nxt(st_nxt), .accept(accept), .fin(fin), .cap(cap)
  );

  sram_lane_pins #(.AW(AW), .DW(DW), .LANES(LANES)) u_pins (
    .clk(clk), .rst(rst), .st(st), .st_nxt(st_nxt),
    .accept(accept), .fin(fin), .cap(cap),
    .addr(addr), .wdata(wdata), .mask(mask),
    .dq_in(sram_dq), .dq_out(dq_out), .drv(drv),
    .pin_addr(sram_addr), .pin_cs_n(sram_cs_n),
    .pin_we_n(sram_we_n), .pin_oe_n(sram_oe_n),
    .done(done), .rdata(rdata)
  );

  assign sram_dq = drv ? dq_out : {DW{1'bz}};

endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

  localparam int AW = 19, DW = 32, LN = 4;
  localparam int T_SA = 1, T_PWE = 2, T_HD = 1, T_TURN = 1, T_AA = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req, wr, done;
  logic [AW-1:0] addr, sram_addr;
  logic [DW-1:0] wdata, rdata;
  logic [LN-1:0] mask, sram_cs_n;
  logic sram_we_n, sram_oe_n;
  wire  [DW-1:0] sram_dq;

  sram_lane_ctrl #(
    .AW(AW), .DW(DW), .LANES(LN),
    .T_SA(T_SA), .T_PWE(T_PWE), .T_HD(T_HD), .T_TURN(T_TURN), .T_AA(T_AA)
  ) u_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .mask(mask), .done(done), .rdata(rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq(sram_dq)
  );

  // behavioural asynchronous memory on the pins
  logic [DW-1:0] smem [256];
  logic [DW-1:0] ref_mem [256];
  initial for (int i = 0; i < 256; i++) begin smem[i] = '0; ref_mem[i] = '0; end

  for (genvar g = 0; g < LN; g++) begin : g_mem
    assign sram_dq[g*8 +: 8] = (!sram_cs_n[g] && sram_we_n && !sram_oe_n)
                               ? smem[sram_addr[7:0]][g*8 +: 8] : 8'hzz;
  end

  always @(negedge clk) begin
    if (!rst && !sram_we_n)
      for (int l = 0; l < LN; l++)
        if (!sram_cs_n[l]) smem[sram_addr[7:0]][l*8 +: 8] = sram_dq[l*8 +: 8];
  end

  // reference model: one expected pin vector per cycle
  typedef struct {
    logic [LN-1:0] cs; logic we, oe, dn;
    logic ca; logic [AW-1:0] a;
    logic cd; logic [DW-1:0] d;
    logic cr; logic [DW-1:0] r;
    string rq;
  } pv_t;
  pv_t expq[$];

  int checks = 0, fails = 0;
  bit started = 0, ended = 0;

  function automatic pv_t mk(logic [LN-1:0] cs, logic we, logic oe, logic dn,
                             logic ca, logic [AW-1:0] a, logic cd, logic [DW-1:0] d,
                             logic cr, logic [DW-1:0] r, string rq);
    pv_t v;
    v.cs = cs; v.we = we; v.oe = oe; v.dn = dn; v.ca = ca; v.a = a;
    v.cd = cd; v.d = d; v.cr = cr; v.r = r; v.rq = rq;
    return v;
  endfunction

  function automatic logic [DW-1:0] xm(logic [LN-1:0] m);
    logic [DW-1:0] b;
    for (int l = 0; l < LN; l++) b[l*8 +: 8] = {8{m[l]}};
    return b;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) started <= 1'b1;

  always @(negedge clk) begin
    pv_t v;
    if (started && !ended) begin
      if (rst) v = mk('1, 1, 1, 0, 0, '0, 0, '0, 1, '0, "R1");
      else if (expq.size() > 0) v = expq.pop_front();
      else v = mk('1, 1, 1, 0, 0, '0, 0, '0, 0, '0, "R9");
      chk({sram_cs_n, sram_we_n, sram_oe_n} == {v.cs, v.we, v.oe}, v.rq, "strobes cs/we/oe",
          {26'd0, sram_cs_n, sram_we_n, sram_oe_n}, {26'd0, v.cs, v.we, v.oe});
      chk(done == v.dn, "R7", "done", {31'd0, done}, {31'd0, v.dn});
      if (v.ca) chk(sram_addr == v.a, "R3", "address pins", {13'd0, sram_addr}, {13'd0, v.a});
      if (v.cd) chk(sram_dq == v.d, "R3", "write data on bus", sram_dq, v.d);
      if (v.cr) chk(rdata == v.r, rst ? "R1" : "R7", "rdata", rdata, v.r);
    end
  end

  task automatic acc(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [LN-1:0] m, bit hold);
    int len;
    string rq;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; mask = m;
    @(posedge clk);
    if (w) begin
      rq = hold ? "R8" : ((m != '1) ? "R4" : "R2");
      for (int i = 0; i < T_SA; i++)  expq.push_back(mk('1, 1, 1, 0, 1, a, 1, d, 0, '0, rq));
      for (int i = 0; i < T_PWE; i++) expq.push_back(mk(~m, 0, 1, 0, 1, a, 1, d, 0, '0, rq));
      for (int i = 0; i < T_HD; i++)  expq.push_back(mk('1, 1, 1, 0, 1, a, 1, d, 0, '0, "R3"));
      expq.push_back(mk('1, 1, 1, 1, 0, '0, 0, '0, 0, '0, "R3"));
      for (int l = 0; l < LN; l++) if (m[l]) ref_mem[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
      len = T_SA + T_PWE + T_HD + 1;
    end else begin
      rq = hold ? "R8" : "R6";
      for (int i = 0; i < T_TURN; i++) expq.push_back(mk(~m, 1, 1, 0, 1, a, 0, '0, 0, '0, rq));
      for (int i = 0; i < T_AA; i++)   expq.push_back(mk(~m, 1, 0, 0, 1, a, 0, '0, 0, '0, rq));
      expq.push_back(mk('1, 1, 1, 1, 0, '0, 0, '0, 1, ref_mem[a[7:0]] & xm(m), "R7"));
      len = T_TURN + T_AA + 1;
    end
    @(negedge clk);
    if (hold) begin
      addr = a ^ 19'h00077; wdata = ~d; mask = ~m; wr = ~w;
    end else req = 0;
    repeat (len - 1) @(negedge clk);
    req = 0;
  endtask

  initial begin
    rst = 1; req = 0; wr = 0; addr = '0; wdata = '0; mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    acc(1, 19'h00010, 32'h11223344, 4'hF, 0);  // R2 full write
    acc(0, 19'h00010, 32'h0, 4'hF, 0);         // R6 read after write
    acc(1, 19'h00010, 32'hAABBCCDD, 4'h5, 0);  // R4 lanes 0 and 2
    acc(0, 19'h00010, 32'h0, 4'hF, 0);         // R7 expect 11BB33DD
    acc(0, 19'h00010, 32'h0, 4'h9, 0);         // R7 unselected lanes zero
    acc(1, 19'h0002A, 32'hFFEEDDCC, 4'h8, 0);  // R4 top lane only
    acc(0, 19'h0002A, 32'h0, 4'hF, 0);
    acc(1, 19'h00033, 32'h0BADF00D, 4'hF, 1);  // R8 inputs change while busy
    acc(0, 19'h00033, 32'h0, 4'hF, 1);         // R8
    acc(0, 19'h00044, 32'h0, 4'hF, 0);         // R8 junk address never written
    acc(0, 19'h00010, 32'h0, 4'h0, 0);         // R4 empty mask, no lane selected
    acc(1, 19'h7FFFF, 32'h5A5A5A5A, 4'hF, 0);  // top address
    acc(0, 19'h7FFFF, 32'h0, 4'hF, 0);
    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule